// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block merges the interrupt causes of a UART into one interrupt line and a 4-bit identification code. The code names only the single most urgent pending cause. Six causes are handled:

- receive line status
- receive data available
- receive time-out
- transmit holding register empty
- modem status change
- CTS/RTS flow-control change

A 4-bit enable input selects which causes may raise the line. The logic that detects the underlying conditions sits outside this block.

Line status, modem status and flow-control change arrive as one-cycle event pulses. Each event is held until its own clear strobe. Receive data available and receive time-out are level conditions driven by the receive FIFO logic. The transmit-empty cause is tracked inside the block. It is pending from reset and becomes pending again on each rising edge of the transmitter-empty condition. It is cleared by a write to the holding register, or by a read of the identification code while that code is showing transmit-empty.

Top module: `uart_irq_ident`

## Requirements
- R1: While reset is asserted, `irq` is 0 and `int_id` is 4'h1. The transmit-empty cause is pending from reset, so setting `ier[1]` after reset raises `irq` with code 4'h2.
- R2: Enable bits gate the causes as follows. `ier[0]` gates receive data and receive time-out. `ier[1]` gates transmit-empty. `ier[2]` gates line status. `ier[3]` gates modem status and flow-control change. A cause whose enable bit is 0 never raises `irq`.
- R3: Priority runs from highest to lowest: line status (4'h6), receive time-out or data (one level), transmit-empty (4'h2), modem status (4'h0), flow-control change (4'h8). A lower cause is reported only after every higher enabled cause has gone.
- R4: Receive data alone reports 4'h4. Receive time-out reports 4'hC, and it also takes the code when both receive causes are active.
- R5: The transmit-empty cause clears on `thr_wr`. It also clears on `id_rd` while `int_id` is 4'h2. An `id_rd` while another code is shown leaves it pending.
- R6: A line status, modem status or flow-control event stays pending until its clear strobe. When an event and its clear fall in the same cycle, the event stays pending.
- R7: When no enabled cause is pending, `int_id` is 4'h1 and `irq` is 0. A cause held while disabled is reported once its enable is set.
- R8: `irq` and `int_id` are registered. They reflect a change of any input one clock edge later.
- R9: A rising edge of `tx_empty` makes transmit-empty pending again. This holds even when a clearing `id_rd` falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ier | input | 4 | Interrupt enable bits (see R2) |
| line_evt | input | 1 | Receive line status event pulse |
| line_clr | input | 1 | Clears a held line status event |
| rx_avail | input | 1 | Receive FIFO at or above trigger level |
| rx_tmo | input | 1 | Receive time-out condition |
| tx_empty | input | 1 | Transmit holding register empty condition |
| thr_wr | input | 1 | Transmit holding register write strobe |
| id_rd | input | 1 | Identification code read strobe |
| modem_evt | input | 1 | Modem status change event pulse |
| modem_clr | input | 1 | Clears a held modem status event |
| flow_evt | input | 1 | CTS/RTS flow-control change event pulse |
| flow_clr | input | 1 | Clears a held flow-control event |
| irq | output | 1 | Interrupt output, high while an enabled cause is pending |
| int_id | output | 4 | Code of the highest-priority pending cause |

## Verification
Two pairs of operations can fall in the same clock edge. A held event can meet its own clear strobe. A transmitter-empty rising edge can meet the identification read that would clear transmit-empty. The bench drives both operations of each pair on the same negative edge. One cycle later it judges that the cause is still reported as pending, and then that a lone clear does remove it.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int ID_W = 4;

  localparam logic [ID_W-1:0] ID_NONE  = 4'h1;
  localparam logic [ID_W-1:0] ID_LINE  = 4'h6;
  localparam logic [ID_W-1:0] ID_TMO   = 4'hC;
  localparam logic [ID_W-1:0] ID_RXD   = 4'h4;
  localparam logic [ID_W-1:0] ID_THRE  = 4'h2;
  localparam logic [ID_W-1:0] ID_MODEM = 4'h0;
  localparam logic [ID_W-1:0] ID_FLOW  = 4'h8;

  typedef struct packed {
    logic line;
    logic tmo;
    logic rxd;
    logic thre;
    logic modem;
    logic flow;
  } irq_src_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb sr_d = {sr_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign rst_n_sync = sr_q[STAGES-1];
endmodule

// File: rtl/irq_evt_latch.sv
module irq_evt_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_nxt_o
);
  logic pend_q;
  logic pend_d;

  // a new event wins over a clear in the same cycle
  always_comb pend_d = set_i | (pend_q & ~clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_nxt_o = pend_d;

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pend_q);
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !pend_q);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr_i) |=> pend_q);
endmodule

// File: rtl/irq_thre_track.sv
module irq_thre_track (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_empty,
  input  logic thr_wr,
  input  logic id_rd,
  input  logic shown_i,
  output logic pend_nxt_o
);
  logic pend_q, pend_d;
  logic empty_q;
  logic rise, clr;

  always_comb begin
    rise   = tx_empty & ~empty_q;
    clr    = thr_wr | (id_rd & shown_i);
    pend_d = rise | (pend_q & ~clr);
  end

  // pending out of reset; edge history starts as "empty"
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b1;
      empty_q <= 1'b1;
    end else begin
      pend_q  <= pend_d;
      empty_q <= tx_empty;
    end
  end

  assign pend_nxt_o = pend_d;

  p_thre_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !(tx_empty && !empty_q)) |=> !pend_q);
  p_thre_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !empty_q) |=> pend_q);
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
(
  input  irq_src_t            pend_i,
  output logic [ID_W-1:0]     code_o
);
  always_comb begin
    if      (pend_i.line)  code_o = ID_LINE;
    else if (pend_i.tmo)   code_o = ID_TMO;
    else if (pend_i.rxd)   code_o = ID_RXD;
    else if (pend_i.thre)  code_o = ID_THRE;
    else if (pend_i.modem) code_o = ID_MODEM;
    else if (pend_i.flow)  code_o = ID_FLOW;
    else                   code_o = ID_NONE;
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      ier,
  input  logic            line_evt,
  input  logic            line_clr,
  input  logic            rx_avail,
  input  logic            rx_tmo,
  input  logic            tx_empty,
  input  logic            thr_wr,
  input  logic            id_rd,
  input  logic            modem_evt,
  input  logic            modem_clr,
  input  logic            flow_evt,
  input  logic            flow_clr,
  output logic            irq,
  output logic [ID_W-1:0] int_id
);
  localparam int N_EVT = 3;
  localparam int E_LINE = 0, E_MODEM = 1, E_FLOW = 2;

  logic             rst_n_s;
  logic [N_EVT-1:0] ev_set, ev_clr, ev_nxt;
  logic             thre_nxt;
  irq_src_t         pend;
  logic [ID_W-1:0]  id_d, id_q;
  logic             irq_d, irq_q;

  irq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  always_comb begin
    ev_set = '0;
    ev_clr = '0;
    ev_set[E_LINE]  = line_evt;   ev_clr[E_LINE]  = line_clr;
    ev_set[E_MODEM] = modem_evt;  ev_clr[E_MODEM] = modem_clr;
    ev_set[E_FLOW]  = flow_evt;   ev_clr[E_FLOW]  = flow_clr;
  end

  for (genvar g = 0; g < N_EVT; g++) begin : g_evt
    irq_evt_latch u_lat (
      .clk(clk), .rst_n(rst_n_s),
      .set_i(ev_set[g]), .clr_i(ev_clr[g]),
      .pend_nxt_o(ev_nxt[g]));
  end

  irq_thre_track u_thre (
    .clk(clk), .rst_n(rst_n_s),
    .tx_empty(tx_empty), .thr_wr(thr_wr), .id_rd(id_rd),
    .shown_i(id_q == ID_THRE),
    .pend_nxt_o(thre_nxt));

  // enable gating
  always_comb begin
    pend.line  = ev_nxt[E_LINE]  & ier[2];
    pend.tmo   = rx_tmo          & ier[0];
    pend.rxd   = rx_avail        & ier[0];
    pend.thre  = thre_nxt        & ier[1];
    pend.modem = ev_nxt[E_MODEM] & ier[3];
    pend.flow  = ev_nxt[E_FLOW]  & ier[3];
  end

  irq_prio_enc u_enc (.pend_i(pend), .code_o(id_d));

  always_comb irq_d = (id_d != ID_NONE);

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      id_q  <= ID_NONE;
      irq_q <= 1'b0;
    end else begin
      id_q  <= id_d;
      irq_q <= irq_d;
    end
  end

  assign int_id = id_q;
  assign irq    = irq_q;

  p_masked_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ier == 4'h0) |=> !irq);
  p_line_first_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (line_evt && ier[2]) |=> (int_id == ID_LINE));
  p_tmo_wins_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rx_tmo && ier[0] && !(ev_nxt[E_LINE] && ier[2])) |=> (int_id == ID_TMO));
  p_none_low_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (int_id == ID_NONE) |-> !irq);
endmodule

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] ier;
  logic line_evt, line_clr, rx_avail, rx_tmo, tx_empty, thr_wr, id_rd;
  logic modem_evt, modem_clr, flow_evt, flow_clr;
  logic       irq;
  logic [3:0] int_id;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  uart_irq_ident dut (
    .clk(clk), .rst_n(rst_n), .ier(ier),
    .line_evt(line_evt), .line_clr(line_clr),
    .rx_avail(rx_avail), .rx_tmo(rx_tmo),
    .tx_empty(tx_empty), .thr_wr(thr_wr), .id_rd(id_rd),
    .modem_evt(modem_evt), .modem_clr(modem_clr),
    .flow_evt(flow_evt), .flow_clr(flow_clr),
    .irq(irq), .int_id(int_id));

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [3:0] exp_id, logic exp_irq);
    checks++;
    if (int_id !== exp_id || irq !== exp_irq) begin
      errors++;
      $display("FAIL %s: id=%h irq=%b expected id=%h irq=%b",
               req, int_id, irq, exp_id, exp_irq);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ier = 4'h0;
    line_evt = 0; line_clr = 0; rx_avail = 0; rx_tmo = 0;
    tx_empty = 1; thr_wr = 0; id_rd = 0;
    modem_evt = 0; modem_clr = 0; flow_evt = 0; flow_clr = 0;
    step(); step();
    chk("R1 in reset", 4'h1, 1'b0);
    rst_n = 1'b1;
    step(); step(); step();
    chk("R1 after release, all disabled", 4'h1, 1'b0);
    ier = 4'b0010; step();
    chk("R1/R8 thre pending from reset", 4'h2, 1'b1);
    id_rd = 1; step(); id_rd = 0;
    chk("R5 read while thre shown clears", 4'h1, 1'b0);
  endtask

  task automatic t_thre();
    tx_empty = 0; step(); tx_empty = 1; step();
    chk("R9 rising tx_empty re-arms", 4'h2, 1'b1);
    thr_wr = 1; step(); thr_wr = 0;
    chk("R5 write clears thre", 4'h1, 1'b0);
    ier = 4'b0110;
    tx_empty = 0; line_evt = 1; step(); line_evt = 0;
    tx_empty = 1; step();
    chk("R3 line over thre", 4'h6, 1'b1);
    id_rd = 1; step(); id_rd = 0;
    chk("R5 read while line shown", 4'h6, 1'b1);
    line_clr = 1; step(); line_clr = 0;
    chk("R5 thre survived other read", 4'h2, 1'b1);
    tx_empty = 0; step();
    tx_empty = 1; id_rd = 1; step(); id_rd = 0;
    chk("R9 rise beats clearing read", 4'h2, 1'b1);
    thr_wr = 1; step(); thr_wr = 0;
    chk("R5 write clears thre again", 4'h1, 1'b0);
  endtask

  task automatic t_priority();
    ier = 4'b1111;
    flow_evt = 1; step(); flow_evt = 0;
    chk("R3 flow alone", 4'h8, 1'b1);
    modem_evt = 1; step(); modem_evt = 0;
    chk("R3 modem over flow", 4'h0, 1'b1);
    tx_empty = 0; step(); tx_empty = 1; step();
    chk("R3 thre over modem", 4'h2, 1'b1);
    rx_avail = 1; step();
    chk("R3 rx data over thre", 4'h4, 1'b1);
    line_evt = 1; step(); line_evt = 0;
    chk("R3 line over rx", 4'h6, 1'b1);
    line_clr = 1; step(); line_clr = 0;
    chk("R3 unwind to rx", 4'h4, 1'b1);
    rx_avail = 0; step();
    chk("R3 unwind to thre", 4'h2, 1'b1);
    thr_wr = 1; step(); thr_wr = 0;
    chk("R3 unwind to modem", 4'h0, 1'b1);
    modem_clr = 1; step(); modem_clr = 0;
    chk("R3 flow only after all higher", 4'h8, 1'b1);
    flow_clr = 1; step(); flow_clr = 0;
    chk("R7 nothing pending", 4'h1, 1'b0);
  endtask

  task automatic t_rx();
    ier = 4'b1110; rx_avail = 1; rx_tmo = 1; step();
    chk("R2 rx causes masked by ier[0]", 4'h1, 1'b0);
    ier = 4'b0001; step();
    chk("R2/R4 both rx causes, tmo code", 4'hC, 1'b1);
    rx_tmo = 0; step();
    chk("R4 data alone", 4'h4, 1'b1);
    rx_avail = 0; rx_tmo = 1; step();
    chk("R4 tmo alone", 4'hC, 1'b1);
    rx_tmo = 0; step();
    chk("R8 rx dropped", 4'h1, 1'b0);
  endtask

  task automatic t_latch();
    ier = 4'b0100;
    line_evt = 1; step(); line_evt = 0;
    chk("R6 line held", 4'h6, 1'b1);
    line_evt = 1; line_clr = 1; step(); line_evt = 0; line_clr = 0;
    chk("R6 event beats clear", 4'h6, 1'b1);
    line_clr = 1; step(); line_clr = 0;
    chk("R6 clear alone", 4'h1, 1'b0);
    ier = 4'b1000;
    modem_evt = 1; step(); modem_evt = 0;
    step(); step(); step();
    chk("R6 modem held for cycles", 4'h0, 1'b1);
    modem_clr = 1; step(); modem_clr = 0;
    chk("R6 modem cleared", 4'h1, 1'b0);
  endtask

  task automatic t_hidden();
    ier = 4'b0000;
    flow_evt = 1; step(); flow_evt = 0;
    chk("R7/R2 disabled flow hidden", 4'h1, 1'b0);
    ier = 4'b1000; step();
    chk("R7 held flow shown when enabled", 4'h8, 1'b1);
    flow_clr = 1; step(); flow_clr = 0;
    chk("R7 flow cleared", 4'h1, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_thre();
    t_priority();
    t_rx();
    t_latch();
    t_hidden();
    finish_run();
  end
endmodule